// File: doc/BRIEF.md
# Two-Wire Configuration Slave with Deferred Nonvolatile Commit

This block is a byte-oriented serial slave on a two-wire bus (an I2C-style clock line and data line). It holds two configuration registers: a prescaler/control register and an address/control register. It also keeps a second copy of both registers that stands for nonvolatile storage. The bus lines are oversampled by the system clock, and the slave drives the data line only through an open-drain pull-down output.

A master selects the device with an address byte. It writes a register pointer and then either data bytes or nothing. To read, it sends a repeated START and a read address. Copying the live registers into the shadow copy is called a commit, and the write-control bit decides when it happens. When that bit is clear, every register write commits. When it is set, only the commit command commits, except that writes to the address register always commit. Each commit opens a busy window. During that window the slave refuses all traffic by leaving the data line released in the acknowledge slot.

Top module: `twi_cfg_slave`

## Requirements
- R1: The device byte is `1011` in bits 7..4, then the three address bits A2..A0 currently used for matching in bits 3..1, then the direction bit in bit 0 (0 = write, 1 = read). A matching byte is acknowledged by pulling SDA low in the ninth clock. A byte that does not match gets no acknowledge, and SDA stays released until the next START.
- R2: A START (SDA falls while SCL is high) restarts address reception from any state, including in the middle of a byte. A STOP (SDA rises while SCL is high) returns the slave to idle from any state.
- R3: Pointer `02h` selects the prescaler register. On the acknowledge of a data byte, data bits 5..0 are stored: bit 5 is the output low/high-impedance select, bit 4 is the dither depth and bits 3..0 are the divide code. A read returns ones in bits 7..6.
- R4: Pointer `0Dh` selects the address register. Data bit 3 is the write-control bit and bits 2..0 are A2..A0. A read returns ones in bits 7..4. The register resets to `F0h` as read.
- R5: A new A2..A0 is used for matching only after the next STOP. Until then, repeated STARTs in the same transfer still match the old address.
- R6: With write-control at 0, a write to `02h` also copies both live registers into the shadow copy.
- R7: With write-control at 1, a write to `02h` leaves the shadow copy unchanged and opens no busy window. A transfer whose pointer byte is `3Fh` commits both registers and carries no data.
- R8: A write to `0Dh` commits both registers, whatever the write-control bit holds.
- R9: A commit keeps the slave busy for COMMIT_CYCLES clock cycles. While it is busy, every address, pointer or data byte is not acknowledged and no register changes. After the window ends, normal responses resume.
- R10: In a read, the slave shifts the selected register out MSB first. Its data output changes only while SCL is low. A master acknowledge makes it send the same register again. A master not-acknowledge makes it release SDA.
- R11: A pointer other than `02h`, `0Dh` or `3Fh` is acknowledged. Writes to it change nothing, and reads from it return `FFh`.
- R12: After reset, the live and shadow registers hold PRE_INIT and ADR_INIT and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |
| pre_live_o | output | 6 | Live prescaler/control bits 5..0 |
| adr_live_o | output | 4 | Live write-control bit and A2..A0 |
| pre_nv_o | output | 6 | Shadow (nonvolatile) prescaler/control bits |
| adr_nv_o | output | 4 | Shadow (nonvolatile) write-control and A2..A0 |

## Verification
On every cycle, the assertions check four things. No write or commit is accepted while the busy window is open. The shadow copy stays frozen during that window. Any byte that arrives while busy, or a device byte that does not match, ends without a pull-down. The data output only moves while SCL is low. The bench scenarios are needed for the rest. They show the register encodings and read-back ones, and the choice between auto-commit and explicit commit. They show the address change that waits for a STOP, and the repeated same-register reads that the master controls with its acknowledges.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;
   localparam int PRE_W = 6;
   localparam int ADR_W = 4;
   localparam int WC_BIT = 3;
   localparam logic [7:0] PTR_PRE = 8'h02;
   localparam logic [7:0] PTR_ADR = 8'h0D;
   localparam logic [7:0] PTR_CMT = 8'h3F;

   typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} twi_state_e;
   typedef enum logic [1:0] {K_DEV, K_PTR, K_DATA} rx_kind_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("twi_line_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_q, sda_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= scl_i;
               sda_ff <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= {scl_ff[STAGES-2:0], scl_i};
               sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_cfg_regs.sv
module twi_cfg_regs
   import twi_cfg_pkg::*;
#(
   parameter int               COMMIT_CYCLES = 600,
   parameter logic [PRE_W-1:0] PRE_INIT      = '0,
   parameter logic [ADR_W-1:0] ADR_INIT      = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_ptr,
   input  logic [PRE_W-1:0] wr_data,
   input  logic             cmd_commit,
   input  logic [7:0]       rd_ptr,
   output logic [7:0]       rd_data,
   output logic [PRE_W-1:0] pre_live,
   output logic [ADR_W-1:0] adr_live,
   output logic [PRE_W-1:0] pre_nv,
   output logic [ADR_W-1:0] adr_nv,
   output logic             busy
);
   localparam int CW = $clog2(COMMIT_CYCLES + 1);

   generate
      if (COMMIT_CYCLES < 1) begin : g_bad_commit
         $error("twi_cfg_regs: COMMIT_CYCLES must be at least 1");
      end
   endgenerate

   logic [PRE_W-1:0] pre_nx;
   logic [ADR_W-1:0] adr_nx;
   logic             commit_go;
   logic [CW-1:0]    busy_cnt;

   always_comb begin
      pre_nx    = pre_live;
      adr_nx    = adr_live;
      commit_go = 1'b0;
      if (wr_en && wr_ptr == PTR_PRE) begin
         pre_nx    = wr_data;
         commit_go = ~adr_live[WC_BIT];
      end
      if (wr_en && wr_ptr == PTR_ADR) begin
         adr_nx    = wr_data[ADR_W-1:0];
         commit_go = 1'b1;
      end
      if (cmd_commit) commit_go = 1'b1;
      commit_go = commit_go & ~busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_live <= PRE_INIT;
         adr_live <= ADR_INIT;
         pre_nv   <= PRE_INIT;
         adr_nv   <= ADR_INIT;
         busy_cnt <= '0;
      end else begin
         if (!busy) begin
            pre_live <= pre_nx;
            adr_live <= adr_nx;
         end
         if (commit_go) begin
            pre_nv   <= pre_nx;
            adr_nv   <= adr_nx;
            busy_cnt <= CW'(COMMIT_CYCLES);
         end else if (busy) begin
            busy_cnt <= busy_cnt - CW'(1);
         end
      end
   end

   assign busy = (busy_cnt != '0);

   always_comb begin
      case (rd_ptr)
         PTR_PRE: rd_data = {{(8-PRE_W){1'b1}}, pre_live};
         PTR_ADR: rd_data = {{(8-ADR_W){1'b1}}, adr_live};
         default: rd_data = 8'hFF;
      endcase
   end

   // R9: the protocol side must not hand in a write or commit while busy
   a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!wr_en && !cmd_commit));

   // R9: the shadow copy is frozen for the whole busy window
   a_r9_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(pre_nv) && $stable(adr_nv)));

   // R8: an address-register write always opens a busy window
   a_r8_adr_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ptr == PTR_ADR) |=> busy);

   // R7: with write-control set, a prescaler write leaves the shadow copy
   a_r7_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ptr == PTR_PRE && adr_live[WC_BIT] && !cmd_commit) |=> ($stable(pre_nv) && !busy));
endmodule

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave
   import twi_cfg_pkg::*;
#(
   parameter logic [3:0]       DEV_ID        = 4'b1011,
   parameter int               SYNC_STAGES   = 2,
   parameter int               COMMIT_CYCLES = 600,
   parameter logic [PRE_W-1:0] PRE_INIT      = '0,
   parameter logic [ADR_W-1:0] ADR_INIT      = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_pull_o,
   output logic [PRE_W-1:0] pre_live_o,
   output logic [ADR_W-1:0] adr_live_o,
   output logic [PRE_W-1:0] pre_nv_o,
   output logic [ADR_W-1:0] adr_nv_o
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   twi_state_e state;
   rx_kind_e   kind;
   logic [2:0] cnt;
   logic [7:0] shreg, ptr, rd_data;
   logic       got, rw, pull, busy, addr_hit, byte_end, wr_en, cmd_commit;
   logic [2:0] adr_match;
   logic [PRE_W-1:0] pre_live;
   logic [ADR_W-1:0] adr_live;

   twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   assign addr_hit   = (shreg[7:1] == {DEV_ID, adr_match});
   assign byte_end   = (state == ST_RX) && got && scl_fall;
   assign wr_en      = byte_end && (kind == K_DATA) && !busy;
   assign cmd_commit = byte_end && (kind == K_PTR) && (shreg == PTR_CMT) && !busy;

   twi_cfg_regs #(.COMMIT_CYCLES(COMMIT_CYCLES), .PRE_INIT(PRE_INIT), .ADR_INIT(ADR_INIT)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(ptr), .wr_data(shreg[PRE_W-1:0]),
      .cmd_commit(cmd_commit), .rd_ptr(ptr), .rd_data(rd_data),
      .pre_live(pre_live), .adr_live(adr_live), .pre_nv(pre_nv_o), .adr_nv(adr_nv_o),
      .busy(busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= K_DEV;
         cnt       <= '0;
         shreg     <= '0;
         got       <= 1'b0;
         rw        <= 1'b0;
         ptr       <= '0;
         adr_match <= ADR_INIT[2:0];
         pull      <= 1'b0;
      end else if (start_det) begin
         state <= ST_RX;
         kind  <= K_DEV;
         cnt   <= '0;
         got   <= 1'b0;
         pull  <= 1'b0;
      end else if (stop_det) begin
         state     <= ST_IDLE;
         got       <= 1'b0;
         pull      <= 1'b0;
         adr_match <= adr_live[2:0];
      end else begin
         case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg <= {shreg[6:0], sda_s};
                  cnt   <= cnt + 3'd1;
                  if (cnt == 3'd7) got <= 1'b1;
               end else if (scl_fall && got) begin
                  got <= 1'b0;
                  if (busy || (kind == K_DEV && !addr_hit)) begin
                     state <= ST_IDLE;
                  end else begin
                     pull  <= 1'b1;
                     state <= ST_ACK;
                     if (kind == K_DEV) rw  <= shreg[0];
                     if (kind == K_PTR) ptr <= shreg;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  if (kind == K_DEV && rw) begin
                     state <= ST_TX;
                     shreg <= rd_data;
                     pull  <= ~rd_data[7];
                  end else begin
                     state <= ST_RX;
                     pull  <= 1'b0;
                     kind  <= (kind == K_DEV) ? K_PTR : K_DATA;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (cnt == 3'd7) begin
                     pull  <= 1'b0;
                     state <= ST_MACK;
                  end else begin
                     shreg <= {shreg[6:0], 1'b0};
                     pull  <= ~shreg[6];
                     cnt   <= cnt + 3'd1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  got <= ~sda_s;
               end else if (scl_fall) begin
                  got <= 1'b0;
                  if (got) begin
                     state <= ST_TX;
                     shreg <= rd_data;
                     pull  <= ~rd_data[7];
                     cnt   <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_pull_o = pull;
   assign pre_live_o = pre_live;
   assign adr_live_o = adr_live;

   // R10: the slave only moves its data output while SCL is low
   a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);

   // R2: a START rearms device-byte reception at bit zero
   a_r2_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_RX && kind == K_DEV && cnt == 3'd0));

   // R9: a byte completed while busy is refused and the slave goes idle
   a_r9_nack_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && busy) |=> (state == ST_IDLE && !sda_pull_o));

   // R1: a device byte that does not match never pulls SDA
   a_r1_no_ack_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && kind == K_DEV && !addr_hit) |=> !sda_pull_o);
endmodule

// File: tb/test_twi_cfg_slave.sv
module test_twi_cfg_slave;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;
   localparam int IDLE_WAIT = 700;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_pull_o;
   logic [5:0] pre_live_o, pre_nv_o;
   logic [3:0] adr_live_o, adr_nv_o;
   wire  sda_line = sda_m & ~sda_pull_o;

   int n_checks = 0;
   int n_err = 0;

   typedef struct {
      string       req;
      logic [31:0] val;
   } exp_t;
   exp_t        exp_q[$];
   logic [31:0] act_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   twi_cfg_slave i_twi_cfg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pull_o(sda_pull_o), .pre_live_o(pre_live_o), .adr_live_o(adr_live_o),
      .pre_nv_o(pre_nv_o), .adr_nv_o(adr_nv_o));

   task automatic push_exp(input string req, input logic [31:0] v);
      exp_t e;
      e.req = req;
      e.val = v;
      exp_q.push_back(e);
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   // acknowledge expected: 1 = slave pulled SDA low in the ninth clock
   task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
      logic a;
      push_exp(req, {31'd0, exp_ack});
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      get_bit(a);
      act_q.push_back({31'd0, ~a});
   endtask

   task automatic recv_byte(input logic [7:0] exp_b, input logic mack, input string req);
      logic [7:0] v;
      logic bt;
      push_exp(req, {24'd0, exp_b});
      for (int i = 7; i >= 0; i--) begin
         get_bit(bt);
         v[i] = bt;
      end
      put_bit(~mack);
      act_q.push_back({24'd0, v});
   endtask

   task automatic check_ports(input logic [5:0] pl, input logic [3:0] al,
                              input logic [5:0] pn, input logic [3:0] an, input string req);
      push_exp(req, {11'd0, 1'b0, pl, al, pn, an});
      @(negedge clk);
      act_q.push_back({11'd0, sda_pull_o, pre_live_o, adr_live_o, pre_nv_o, adr_nv_o});
   endtask

   function automatic logic [7:0] dev(input logic [2:0] a, input logic rd);
      return {4'b1011, a, rd};
   endfunction

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] p, input logic [7:0] d, input string req);
      bus_start();
      send_byte(dev(a, 1'b0), 1'b1, req);
      send_byte(p, 1'b1, req);
      send_byte(d, 1'b1, req);
      bus_stop();
   endtask

   task automatic rd_reg(input logic [2:0] a, input logic [7:0] p, input logic [7:0] exp_v, input string req);
      bus_start();
      send_byte(dev(a, 1'b0), 1'b1, req);
      send_byte(p, 1'b1, req);
      bus_start();
      send_byte(dev(a, 1'b1), 1'b1, req);
      recv_byte(exp_v, 1'b0, req);
      bus_stop();
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      idle(5);
      if (exp_q.size() != 0 || act_q.size() != 0) begin
         n_err++;
         $display("FAIL scoreboard: got %0d unmatched results expected %0d", act_q.size(), exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   // monitor: pair each observed result with the next expected item
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            exp_t        e;
            logic [31:0] a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_checks++;
            if (a !== e.val) begin
               n_err++;
               $display("FAIL %s: got %h expected %h", e.req, a, e.val);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(4);
      // R12 reset state
      check_ports(6'h00, 4'h0, 6'h00, 4'h0, "R12 reset");
      // R3, R4 reads of the reset values
      rd_reg(3'd0, 8'h02, 8'hC0, "R3 read prescaler");
      check_ports(6'h00, 4'h0, 6'h00, 4'h0, "R10 release after NACK");
      rd_reg(3'd0, 8'h0D, 8'hF0, "R4 read address reg");
      // R6 auto-commit with write-control clear
      wr_reg(3'd0, 8'h02, 8'h95, "R6 write prescaler");
      check_ports(6'h15, 4'h0, 6'h15, 4'h0, "R6 auto commit");
      // R9 busy window refuses traffic
      bus_start();
      send_byte(dev(3'd0, 1'b0), 1'b0, "R9 busy NACK");
      bus_stop();
      check_ports(6'h15, 4'h0, 6'h15, 4'h0, "R9 unchanged");
      idle(IDLE_WAIT);
      rd_reg(3'd0, 8'h02, 8'hD5, "R3 read back upper ones");
      // R1 mismatching address and identifier
      bus_start();
      send_byte(8'hB2, 1'b0, "R1 wrong A bits");
      bus_stop();
      bus_start();
      send_byte(8'hA0, 1'b0, "R1 wrong identifier");
      bus_stop();
      // R8 address write with write-control clear, sets write-control
      wr_reg(3'd0, 8'h0D, 8'h08, "R8 address write");
      check_ports(6'h15, 4'h8, 6'h15, 4'h8, "R8 commit");
      idle(IDLE_WAIT);
      // R7 deferred commit
      wr_reg(3'd0, 8'h02, 8'h2A, "R7 write deferred");
      check_ports(6'h2A, 4'h8, 6'h15, 4'h8, "R7 shadow held");
      rd_reg(3'd0, 8'h02, 8'hEA, "R7 no busy window");
      // R8 with write-control set, then R5 deferred address match
      bus_start();
      send_byte(dev(3'd0, 1'b0), 1'b1, "R8 dev");
      send_byte(8'h0D, 1'b1, "R8 ptr");
      send_byte(8'h0B, 1'b1, "R8 data");
      check_ports(6'h2A, 4'hB, 6'h2A, 4'hB, "R8 commit with WC set");
      idle(IDLE_WAIT);
      bus_start();
      send_byte(dev(3'd3, 1'b0), 1'b0, "R5 new address before STOP");
      bus_start();
      send_byte(dev(3'd0, 1'b0), 1'b1, "R5 old address before STOP");
      send_byte(8'h02, 1'b1, "R5 ptr");
      bus_stop();
      rd_reg(3'd3, 8'h0D, 8'hFB, "R5 new address after STOP");
      bus_start();
      send_byte(dev(3'd0, 1'b0), 1'b0, "R1 old address refused");
      bus_stop();
      // R7 explicit commit command
      wr_reg(3'd3, 8'h02, 8'h07, "R7 write");
      check_ports(6'h07, 4'hB, 6'h2A, 4'hB, "R7 shadow held");
      bus_start();
      send_byte(dev(3'd3, 1'b0), 1'b1, "R7 cmd dev");
      send_byte(8'h3F, 1'b1, "R7 cmd");
      bus_stop();
      check_ports(6'h07, 4'hB, 6'h07, 4'hB, "R7 command commit");
      bus_start();
      send_byte(dev(3'd3, 1'b0), 1'b0, "R9 busy after command");
      bus_stop();
      idle(IDLE_WAIT);
      bus_start();
      send_byte(dev(3'd3, 1'b0), 1'b1, "R9 resumes");
      bus_stop();
      // R11 unmapped pointer
      wr_reg(3'd3, 8'h10, 8'h55, "R11 write ignored");
      check_ports(6'h07, 4'hB, 6'h07, 4'hB, "R11 no change");
      rd_reg(3'd3, 8'h10, 8'hFF, "R11 read FFh");
      // R10 two-byte read
      bus_start();
      send_byte(dev(3'd3, 1'b0), 1'b1, "R10 dev");
      send_byte(8'h02, 1'b1, "R10 ptr");
      bus_start();
      send_byte(dev(3'd3, 1'b1), 1'b1, "R10 read dev");
      recv_byte(8'hC7, 1'b1, "R10 first byte");
      recv_byte(8'hC7, 1'b0, "R10 repeat byte");
      bus_stop();
      check_ports(6'h07, 4'hB, 6'h07, 4'hB, "R10 released");
      // R2 STOP in the middle of a byte, then a fresh START
      bus_start();
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      bus_stop();
      bus_start();
      send_byte(dev(3'd3, 1'b0), 1'b1, "R2 restart after aborted byte");
      bus_stop();
      finish_run();
   end
endmodule